// File: doc/BRIEF.md
# Serial Memory Write Engine with Busy Polling

This block is a two-wire bus master that carries out one write to a small serial memory and then waits until the memory has finished its internal programming cycle. A requester hands it a row address, two mode bits, a byte count and up to two data bytes. The engine issues a START, the control byte, the data bytes and a STOP. It then keeps probing the memory with START plus control byte. A probe that is not acknowledged means the memory is still busy. It is closed with a STOP and tried again. The first acknowledged probe means programming has ended.

The bus lines are open drain. Each line is modelled as a pull-low enable output, and SDA also has a sampled input. The bit timing comes from a divider: each bus clock period is four quarter-phases of `QDIV` system cycles each. A missing acknowledge during the write itself is an error. Running out of probes (`MAX_POLLS`) is a timeout error. Success, NACK error and timeout are reported as one-cycle pulses.

The request port uses valid/ready. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the cycle of the outcome pulse. The requester must hold its request stable while `req_ready` is low. The engine latches all request fields at acceptance and ignores them afterwards.

Top module: `eeprom_pollwr_master`

## Requirements
- R1: After reset and whenever idle, both bus lines are released (`scl_oe`=0, `sda_oe`=0), `req_ready` is 1 and no outcome pulse is high.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the next cycle and stays 0 until the outcome. Request inputs changed after acceptance have no effect on the bytes sent.
- R3: After a START, the first byte is the control byte {row[4:0], mode[1:0], 1'b0}, with the direction bit 0 meaning write. It is sent MSB first.
- R4: The write sends `req_nbytes` data bytes (0, 1 or 2; the value 3 is treated as 2). Byte `req_data[7:0]` goes first, then `req_data[15:8]`, each MSB first, and a STOP follows.
- R5: If the control byte or a data byte of the write is not acknowledged, the engine sends STOP, pulses `err_nack`, and sends no probe.
- R6: After the write STOP, each probe is a START followed by the same control byte. An unacknowledged probe is followed by STOP and then a new probe.
- R7: An acknowledged probe is followed by STOP, and then `done` pulses for one cycle.
- R8: If `MAX_POLLS` probes in a row are not acknowledged, the engine sends STOP after the last one and pulses `err_timeout`. Exactly `MAX_POLLS` probes are sent.
- R9: `done`, `err_nack` and `err_timeout` are one-cycle pulses. At most one of them is high at a time, and `req_ready` is 1 in the cycle each of them is high.
- R10: SDA changes only while SCL is low, except for START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high). The number of STARTs and the number of STOPs are each 1 + the number of probes.
- R11: The SCL period inside a byte is 4*`QDIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_row | input | 5 | Memory row address |
| req_mode | input | 2 | Byte-order mode bits, placed in the control byte |
| req_nbytes | input | 2 | Data byte count (3 is treated as 2) |
| req_data | input | 16 | Data, bits 7:0 sent first |
| done | output | 1 | Pulse: write and programming finished |
| err_nack | output | 1 | Pulse: write not acknowledged |
| err_timeout | output | 1 | Pulse: probe limit reached |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench models the memory on the wire. The model can refuse to acknowledge the control byte, the first data byte or the second data byte, and it can stay busy for a chosen number of probes. Busy counts of zero, `MAX_POLLS`-1 and `MAX_POLLS` target off-by-one faults in the probe limit: a faulty engine would report a timeout one probe early, or would send one probe too many. A NACK injected on the last data byte catches an engine that treats the write as good and goes on to probing. Counting STARTs and STOPs catches a probe that is not closed with a STOP, and a stray SDA edge while SCL is high. Changing the request fields after acceptance, and a count of 3, expose fields that are not latched and byte counts that are not clamped.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_BYTE  = 2'd2
  } bitcmd_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WSTART,
    SQ_WCTRL,
    SQ_WDATA,
    SQ_STOP,
    SQ_PSTART,
    SQ_PCTRL
  } seq_t;

  typedef enum logic [2:0] {
    FIN_POLL,
    FIN_OK,
    FIN_NACK,
    FIN_RETRY,
    FIN_TMO
  } fin_t;
endpackage

// File: rtl/eepw_qtick.sv
module eepw_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/eepw_bitphy.sv
module eepw_bitphy
  import eepw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  bitcmd_t    cmd,
  input  logic [7:0] cmd_byte,
  output logic       busy,
  output logic       op_done,
  output logic       ack,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);
  bitcmd_t    cur;
  logic [7:0] shreg;
  logic [3:0] bitn;
  logic [1:0] ph;
  logic       last_step;

  always_comb begin
    case (cur)
      BC_BYTE: last_step = (bitn == 4'd8) && (ph == 2'd3);
      default: last_step = (ph == 2'd3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= BC_STOP;
      shreg   <= '0;
      bitn    <= '0;
      ph      <= '0;
      busy    <= 1'b0;
      op_done <= 1'b0;
      ack     <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          cur   <= cmd;
          shreg <= cmd_byte;
          bitn  <= '0;
          ph    <= '0;
          busy  <= 1'b1;
        end
      end else if (tick) begin
        case (cur)
          BC_START: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b0; sda_oe <= 1'b0; end
              2'd1: sda_oe <= 1'b1;
              2'd2: scl_oe <= 1'b1;
              default: ;
            endcase
          end
          BC_STOP: begin
            case (ph)
              2'd0: begin scl_oe <= 1'b1; sda_oe <= 1'b1; end
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: ;
            endcase
          end
          default: begin
            case (ph)
              2'd0: begin
                scl_oe <= 1'b1;
                sda_oe <= (bitn < 4'd8) ? ~shreg[7] : 1'b0;
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: if (bitn == 4'd8) ack <= ~sda_i;
              default: begin
                scl_oe <= 1'b1;
                shreg  <= {shreg[6:0], 1'b0};
                bitn   <= bitn + 1'b1;
              end
            endcase
          end
        endcase
        ph <= ph + 1'b1;
        if (last_step) begin
          busy    <= 1'b0;
          op_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eepw_seq.sv
module eepw_seq
  import eepw_pkg::*;
#(
  parameter int MAX_POLLS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [4:0]  req_row,
  input  logic [1:0]  req_mode,
  input  logic [1:0]  req_nbytes,
  input  logic [15:0] req_data,
  output logic        done,
  output logic        err_nack,
  output logic        err_timeout,
  output logic        cmd_valid,
  output bitcmd_t     cmd,
  output logic [7:0]  cmd_byte,
  input  logic        phy_busy,
  input  logic        phy_done,
  input  logic        phy_ack
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] PLIM = PW'(MAX_POLLS - 1);

  seq_t        st;
  fin_t        fin;
  logic        issued;
  logic [7:0]  ctrl;
  logic [15:0] data_q;
  logic [1:0]  nb_q;
  logic        idx;
  logic [PW-1:0] polls;

  assign req_ready = (st == SQ_IDLE);
  assign cmd_valid = (st != SQ_IDLE) && !issued && !phy_busy;

  always_comb begin
    case (st)
      SQ_WSTART, SQ_PSTART: cmd = BC_START;
      SQ_STOP:              cmd = BC_STOP;
      default:              cmd = BC_BYTE;
    endcase
    if (st == SQ_WDATA) cmd_byte = idx ? data_q[15:8] : data_q[7:0];
    else                cmd_byte = ctrl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      fin         <= FIN_POLL;
      issued      <= 1'b0;
      ctrl        <= '0;
      data_q      <= '0;
      nb_q        <= '0;
      idx         <= 1'b0;
      polls       <= '0;
      done        <= 1'b0;
      err_nack    <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done        <= 1'b0;
      err_nack    <= 1'b0;
      err_timeout <= 1'b0;
      if (cmd_valid) issued <= 1'b1;
      case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            ctrl   <= {req_row, req_mode, 1'b0};
            data_q <= req_data;
            nb_q   <= (req_nbytes == 2'd3) ? 2'd2 : req_nbytes;
            idx    <= 1'b0;
            polls  <= '0;
            issued <= 1'b0;
            st     <= SQ_WSTART;
          end
        end
        default: begin
          if (phy_done) begin
            issued <= 1'b0;
            case (st)
              SQ_WSTART: st <= SQ_WCTRL;
              SQ_WCTRL: begin
                if (!phy_ack) begin
                  fin <= FIN_NACK;
                  st  <= SQ_STOP;
                end else if (nb_q == 2'd0) begin
                  fin <= FIN_POLL;
                  st  <= SQ_STOP;
                end else begin
                  st <= SQ_WDATA;
                end
              end
              SQ_WDATA: begin
                if (!phy_ack) begin
                  fin <= FIN_NACK;
                  st  <= SQ_STOP;
                end else if ({1'b0, idx} + 2'd1 == nb_q) begin
                  fin <= FIN_POLL;
                  st  <= SQ_STOP;
                end else begin
                  idx <= 1'b1;
                end
              end
              SQ_PSTART: st <= SQ_PCTRL;
              SQ_PCTRL: begin
                if (phy_ack)            fin <= FIN_OK;
                else if (polls == PLIM) fin <= FIN_TMO;
                else                    fin <= FIN_RETRY;
                st <= SQ_STOP;
              end
              SQ_STOP: begin
                case (fin)
                  FIN_POLL:  st <= SQ_PSTART;
                  FIN_RETRY: begin
                    polls <= polls + 1'b1;
                    st    <= SQ_PSTART;
                  end
                  FIN_OK: begin
                    done <= 1'b1;
                    st   <= SQ_IDLE;
                  end
                  FIN_NACK: begin
                    err_nack <= 1'b1;
                    st       <= SQ_IDLE;
                  end
                  default: begin
                    err_timeout <= 1'b1;
                    st          <= SQ_IDLE;
                  end
                endcase
              end
              default: st <= SQ_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eeprom_pollwr_master.sv
module eeprom_pollwr_master
  import eepw_pkg::*;
#(
  parameter int QDIV      = 4,
  parameter int MAX_POLLS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [4:0]  req_row,
  input  logic [1:0]  req_mode,
  input  logic [1:0]  req_nbytes,
  input  logic [15:0] req_data,
  output logic        done,
  output logic        err_nack,
  output logic        err_timeout,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_i
);
  logic       tick;
  logic       cmd_valid;
  bitcmd_t    cmd;
  logic [7:0] cmd_byte;
  logic       phy_busy;
  logic       phy_done;
  logic       phy_ack;

  eepw_qtick #(.QDIV(QDIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  eepw_bitphy u_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cmd_valid(cmd_valid),
    .cmd      (cmd),
    .cmd_byte (cmd_byte),
    .busy     (phy_busy),
    .op_done  (phy_done),
    .ack      (phy_ack),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .sda_i    (sda_i)
  );

  eepw_seq #(.MAX_POLLS(MAX_POLLS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_row    (req_row),
    .req_mode   (req_mode),
    .req_nbytes (req_nbytes),
    .req_data   (req_data),
    .done       (done),
    .err_nack   (err_nack),
    .err_timeout(err_timeout),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .cmd_byte   (cmd_byte),
    .phy_busy   (phy_busy),
    .phy_done   (phy_done),
    .phy_ack    (phy_ack)
  );
endmodule

// File: rtl/eepw_chk.sv
module eepw_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic err_nack,
  input logic err_timeout,
  input logic scl_oe,
  input logic sda_oe
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!scl_oe && !sda_oe)); // R1
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_nack, err_timeout})); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_OUTCOME_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_nack || err_timeout) |-> req_ready); // R9
  AST_SDA_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && $past(scl_oe) && (sda_oe != $past(sda_oe))) |-> $past(req_ready) == 1'b0); // R10
endmodule

bind eeprom_pollwr_master eepw_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .err_nack   (err_nack),
  .err_timeout(err_timeout),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe)
);

// File: tb/sim_eeprom_pollwr_master.sv
`timescale 1ns/1ps
module sim_eeprom_pollwr_master;
  localparam int QDIV = 4;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0] req_row = '0;
  logic [1:0] req_mode = '0;
  logic [1:0] req_nbytes = '0;
  logic [15:0] req_data = '0;
  logic done, err_nack, err_timeout, scl_oe, sda_oe;
  logic slv_low = 1'b0;
  wire  scl_bus = !scl_oe;
  wire  sda_bus = !(sda_oe || slv_low);

  always #4 clk = ~clk;

  eeprom_pollwr_master #(.QDIV(QDIV), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_mode(req_mode), .req_nbytes(req_nbytes),
    .req_data(req_data), .done(done), .err_nack(err_nack),
    .err_timeout(err_timeout), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_bus)
  );

  int tests = 0, fails = 0;

  // memory model state
  int nack_at = 9, busy_n = 0;
  int starts = 0, stops = 0, tidx = 0, byt = 0, bitc = 0;
  int wr_n = 0, polls_seen = 0, bad_polls = 0;
  logic [7:0] sh = '0, exp_ctrl = '0;
  logic [7:0] wr_bytes [0:2];
  time t_r0 = 0, t_r1 = 0;

  always @(negedge sda_bus) if (scl_bus) begin
    starts++; tidx++; byt = 0; bitc = 0;
  end
  always @(posedge sda_bus) if (scl_bus) begin
    stops++; bitc = 0;
  end
  always @(posedge scl_bus) begin
    if (tidx == 1 && byt == 0 && bitc == 0) t_r0 = $time;
    if (tidx == 1 && byt == 0 && bitc == 1) t_r1 = $time;
    if (bitc < 8) sh = {sh[6:0], sda_bus};
    if (bitc < 9) bitc++;
  end
  always @(negedge scl_bus) begin
    if (bitc == 8) begin
      if (tidx == 1) begin
        if (byt < 3) wr_bytes[byt] = sh;
        wr_n = byt + 1;
        slv_low = (nack_at != byt);
      end else begin
        if (sh != exp_ctrl) bad_polls++;
        slv_low = ((tidx - 2) >= busy_n);
        polls_seen++;
      end
    end else if (bitc == 9) begin
      slv_low = 1'b0; bitc = 0; byt++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_nb(input int nb);
    return (nb == 3) ? 2 : nb;
  endfunction

  function automatic int exp_polls(input int nb, input int nk, input int bz);
    if (nk <= eff_nb(nb)) return 0;
    return (bz < MAXP) ? bz + 1 : MAXP;
  endfunction

  // outcome: 0 done, 1 nack, 2 timeout
  function automatic int exp_out(input int nb, input int nk, input int bz);
    if (nk <= eff_nb(nb)) return 1;
    return (bz < MAXP) ? 0 : 2;
  endfunction

  task automatic run(input logic [4:0] row, input logic [1:0] mode, input int nb,
                     input logic [15:0] dat, input int nk, input int bz, input bit scramble);
    int got, np, ne, cyc;
    logic [7:0] eb [0:1];
    exp_ctrl = {row, mode, 1'b0};
    eb[0] = dat[7:0]; eb[1] = dat[15:8];
    nack_at = nk; busy_n = bz;
    starts = 0; stops = 0; tidx = 0; wr_n = 0; polls_seen = 0; bad_polls = 0;
    @(negedge clk);
    req_row = row; req_mode = mode; req_nbytes = 2'(nb); req_data = dat; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    if (scramble) begin
      req_row = ~row; req_mode = ~mode; req_data = ~dat; req_nbytes = 2'd0;
    end
    got = -1; cyc = 0;
    while (got < 0 && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (done || err_nack || err_timeout) begin
        got = done ? 0 : (err_nack ? 1 : 2);
        chk((32'(done) + 32'(err_nack) + 32'(err_timeout)) == 1, "R9 single outcome", got, got);
        chk(req_ready == 1'b1, "R9 ready with outcome", req_ready, 1);
        @(negedge clk);
        chk(!done && !err_nack && !err_timeout, "R9 pulse width", {done, err_nack, err_timeout}, 0);
      end
    end
    if (got < 0) chk(1'b0, "watchdog", cyc, 20000);
    ne = (nk <= eff_nb(nb)) ? nk + 1 : eff_nb(nb) + 1;
    chk(wr_n == ne, "R4 write byte count", wr_n, ne);
    chk(wr_bytes[0] == exp_ctrl, "R3 control byte", wr_bytes[0], exp_ctrl);
    for (int k = 1; k < ne; k++)
      chk(wr_bytes[k] == eb[k-1], "R4 data byte order", wr_bytes[k], eb[k-1]);
    np = exp_polls(nb, nk, bz);
    chk(polls_seen == np, (np == 0) ? "R5 no probe after nack" : "R6 probe count",
        polls_seen, np);
    chk(bad_polls == 0, "R6 probe control byte", bad_polls, 0);
    chk(starts == 1 + np && stops == 1 + np, "R10 start/stop count", starts * 100 + stops,
        (1 + np) * 101);
    case (exp_out(nb, nk, bz))
      0: chk(got == 0, "R7 done after ack", got, 0);
      1: chk(got == 1, "R5 nack error", got, 1);
      default: chk(got == 2, "R8 timeout", got, 2);
    endcase
    chk(!scl_oe && !sda_oe, "R1 bus released after outcome", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    int r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(req_ready && !scl_oe && !sda_oe && !done && !err_nack && !err_timeout,
        "R1 reset state", {req_ready, scl_oe, sda_oe}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(5'h15, 2'b10, 2, 16'hA53C, 9, 0, 1'b1);   // R2 scramble after accept, R7
    chk((t_r1 - t_r0) == time'(4 * QDIV * 8), "R11 scl period", t_r1 - t_r0, 4 * QDIV * 8);
    run(5'h1F, 2'b01, 0, 16'h0000, 9, 2, 1'b0);   // R4 zero bytes
    run(5'h03, 2'b11, 3, 16'h1234, 9, 1, 1'b0);   // R4 count 3 clamped
    run(5'h0A, 2'b00, 2, 16'hFFFF, 0, 0, 1'b0);   // R5 nack on control byte
    run(5'h0B, 2'b00, 2, 16'h8001, 2, 0, 1'b0);   // R5 nack on last data byte
    run(5'h11, 2'b10, 1, 16'h00C3, 9, MAXP - 1, 1'b0); // R6 last-chance probe
    run(5'h12, 2'b01, 1, 16'h005A, 9, MAXP, 1'b0);     // R8 timeout
    // constrained random
    for (int i = 0; i < 16; i++) begin
      int nb, nk, bz;
      nb = int'($urandom % 4);
      nk = ($urandom % 5 == 0) ? int'($urandom % (eff_nb(nb) + 1)) : 9;
      bz = int'($urandom % (MAXP + 2));
      run(5'($urandom), 2'($urandom), nb, 16'($urandom), nk, bz, 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++; tests++;
    $display("FAIL watchdog global timeout actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule